// File: doc/BRIEF.md
# Integer Twin-Butterfly Multiply and Round-Shift Unit

This block performs one butterfly step of an integer DCT or FFT. It samples three signed words in a single cycle: a value `a` that stands for the primary destination's old contents, a second value `b`, and a shared coefficient `c`. It also samples a 5-bit shift amount. From that one sample it forms both `a+b` and `a-b`, one bit wider than the operands, and multiplies each by `c` into a full-width signed product. Each product is then rounded to nearest by adding half of the discarded weight and shifted right arithmetically.

Both results are registered together and appear one cycle after the strobe. The sum result goes out on the primary bus and the difference result on the secondary bus, which models the implicit register paired above the primary. A typical codec use is a shift of 14 with cosine coefficients near 2^14. In that case each output equals `((x0 +/- x1) * c + 8192) >> 14`. A shift of zero gives the plain low word of each product with no rounding.

Top module: `tbf_twin_butterfly`

## Requirements
- R1: The sum and the difference are formed at XLEN+1 bits, so an operand pair at the signed extremes does not wrap before the multiply. For example, a = b = 2^(XLEN-1)-1, c = 1 and shift 1 give 2^(XLEN-1)-1 on the primary output.
- R2: Each widened sum or difference is multiplied by `coef` as a two's-complement signed value, so negative coefficients and negative operands give correctly signed products.
- R3: With `shamt` = 0, each output is the low XLEN bits of its product, with no rounding term added.
- R4: With `shamt` = n, for n from 1 to 31, each output is bits [XLEN+n-1:n] of (product + 2^(n-1)). This is the low XLEN bits of the rounded product shifted right arithmetically by n.
- R5: Rounding goes to nearest with ties toward positive infinity. At shift 1, a product of -3 gives -1, a product of -1 gives 0, and a product of 3 gives 2.
- R6: `res_pri` carries the result of the (a+b) path and `res_sec` carries the result of the (a-b) path. The difference is a minus b, never b minus a.
- R7: Both outputs of one strobe come from the same sampled `op_a`, `op_b`, `coef` and `shamt`. Strobes on consecutive cycles give results in the same order, one result pair per strobe.
- R8: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R9: While `in_valid` is low, `res_pri` and `res_sec` keep their last values.
- R10: While `rst_n` is low, `out_valid`, `res_pri` and `res_sec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe that samples the operands in this cycle |
| op_a | input | XLEN | Signed first operand (old primary destination value) |
| op_b | input | XLEN | Signed second operand |
| coef | input | XLEN | Signed shared coefficient |
| shamt | input | 5 | Right-shift amount; 0 selects truncation with no rounding |
| out_valid | output | 1 | High for one cycle when a result pair is presented |
| res_pri | output | XLEN | Rounded-shifted (a+b)*c, primary destination |
| res_sec | output | XLEN | Rounded-shifted (a-b)*c, secondary destination |

## Verification
Two things can fall in the same clock edge: a new operand set is sampled while the result pair of the previous strobe is presented. The bench provokes this with strings of strobes on consecutive cycles that carry varied shifts, signs and coefficients. A scoreboard queue judges the outcome: each output pair must match its own strobe's expected values, in strobe order. A result that had leaked from the next sample, or one that was lost, shows up as a mismatch or as a leftover queue entry. Idle gaps between the bursts confirm that the outputs hold their values and that `out_valid` drops.

// File: rtl/tbf_pkg.sv
// Package: tbf_pkg
// Shared constants and types for the twin-butterfly unit.
// Assumes the shift field is always 5 bits wide.
package tbf_pkg;
    localparam int SHW = 5;
    localparam int NLANES = 2;

    typedef logic [SHW-1:0] shamt_t;

    // Lane index: the sum lane drives the primary bus, the difference lane the secondary bus.
    typedef enum int {
        LANE_SUM  = 0,
        LANE_DIFF = 1
    } lane_e;
endpackage

// File: rtl/tbf_preadd.sv
// Module: tbf_preadd
// Forms a+b and a-b at XLEN+1 bits from the two signed operands.
// Assumes two's-complement inputs. The extra bit means neither result can wrap.
module tbf_preadd #(
    parameter int XLEN = 64
) (
    input  logic signed [XLEN-1:0] a_i,
    input  logic signed [XLEN-1:0] b_i,
    output logic signed [XLEN:0]   sum_o,
    output logic signed [XLEN:0]   diff_o
);
    logic signed [XLEN:0] a_ext;
    logic signed [XLEN:0] b_ext;

    // Purpose: sign-extend both operands by one bit.
    always_comb begin
        a_ext = {a_i[XLEN-1], a_i};
        b_ext = {b_i[XLEN-1], b_i};
    end

    // Purpose: widened sum and difference (a minus b).
    always_comb begin
        sum_o  = a_ext + b_ext;
        diff_o = a_ext - b_ext;
    end
endmodule

// File: rtl/tbf_lane.sv
// Module: tbf_lane
// One multiply and round-shift lane. It multiplies a widened operand by the
// signed coefficient, adds 2^(n-1) when n > 0, shifts right arithmetically by n,
// and keeps the low XLEN bits. Combinational; the top registers the result.
// Assumes shamt <= 31.
module tbf_lane
    import tbf_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic signed [XLEN:0]   opnd_i,
    input  logic signed [XLEN-1:0] coef_i,
    input  shamt_t                 shamt_i,
    output logic [XLEN-1:0]        res_o
);
    localparam int PW = 2 * XLEN + 1;
    localparam logic signed [PW-1:0] ONE = PW'(1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    logic signed [PW-1:0] biased;

    // Purpose: full-width signed product.
    always_comb begin
        prod = PW'(opnd_i) * PW'(coef_i);
    end

    // Purpose: rounding term, half of the discarded weight, or zero for truncation.
    always_comb begin
        if (shamt_i == '0)
            rnd = '0;
        else
            rnd = ONE <<< (shamt_i - SHW'(1));
    end

    // Purpose: add the rounding term, shift arithmetically, keep the low word.
    always_comb begin
        biased = prod + rnd;
        res_o  = XLEN'(biased >>> shamt_i);
    end
endmodule

// File: rtl/tbf_twin_butterfly.sv
// Module: tbf_twin_butterfly
// Twin-butterfly unit. On an in_valid cycle it evaluates round-shift((a+b)*c)
// and round-shift((a-b)*c) from the same sampled inputs and registers both.
// out_valid follows one cycle later. The outputs hold their values while idle.
// Assumes a synchronous active-low reset.
module tbf_twin_butterfly
    import tbf_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [XLEN-1:0]  op_a,
    input  logic signed [XLEN-1:0]  op_b,
    input  logic signed [XLEN-1:0]  coef,
    input  logic [SHW-1:0]          shamt,
    output logic                    out_valid,
    output logic [XLEN-1:0]         res_pri,
    output logic [XLEN-1:0]         res_sec
);
    logic signed [XLEN:0] lane_opnd [NLANES];
    logic [XLEN-1:0]      lane_res  [NLANES];
    logic [XLEN-1:0]      res_q     [NLANES];

    tbf_preadd #(.XLEN(XLEN)) u_preadd (
        .a_i    (op_a),
        .b_i    (op_b),
        .sum_o  (lane_opnd[LANE_SUM]),
        .diff_o (lane_opnd[LANE_DIFF])
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        tbf_lane #(.XLEN(XLEN)) u_lane (
            .opnd_i  (lane_opnd[g]),
            .coef_i  (coef),
            .shamt_i (shamt),
            .res_o   (lane_res[g])
        );

        // Purpose: capture this lane's result on a strobe; hold it otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                res_q[g] <= '0;
            else if (in_valid)
                res_q[g] <= lane_res[g];
        end
    end

    // Purpose: one-cycle valid flag that tracks the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    // Purpose: route the sum lane to the primary bus and the difference lane to the secondary bus.
    always_comb begin
        res_pri = res_q[LANE_SUM];
        res_sec = res_q[LANE_DIFF];
    end
endmodule

// File: rtl/tbf_twin_butterfly_chk.sv
// Module: tbf_twin_butterfly_chk
// Assertion checker for tbf_twin_butterfly, attached with bind. It watches
// the ports only.
module tbf_twin_butterfly_chk #(
    parameter int XLEN = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic signed [XLEN-1:0] op_a,
    input logic signed [XLEN-1:0] op_b,
    input logic signed [XLEN-1:0] coef,
    input logic [4:0]             shamt,
    input logic                   out_valid,
    input logic [XLEN-1:0]        res_pri,
    input logic [XLEN-1:0]        res_sec
);
    // R8: a strobe gives a valid pulse in the next cycle.
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8: no strobe, no valid in the next cycle.
    p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: idle cycles leave both results unchanged.
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_pri) && $stable(res_sec)));

    // R2: a zero coefficient yields zero on both buses at any shift.
    p_zero_coef_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && coef == '0) |=> (res_pri == '0 && res_sec == '0));

    // R6: a zero second operand makes the sum and difference lanes agree.
    p_b_zero_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_b == '0) |=> (res_pri == res_sec));

    // R7: equal operands give a zero difference result from the same sample.
    p_equal_ops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_a == op_b) |=> (res_sec == '0));

    // R3: unit coefficient at zero shift gives the wrapped sum on the primary bus.
    p_trunc_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shamt == 5'd0 && coef == XLEN'(1))
            |=> (res_pri == XLEN'($past(op_a) + $past(op_b))));
endmodule

bind tbf_twin_butterfly tbf_twin_butterfly_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tbf_twin_butterfly_bench.sv
// Bench: scoreboard driven. The driver task pushes expected pairs, and the
// monitor pops and compares them whenever out_valid is seen.
module tbf_twin_butterfly_bench;
    localparam int XLEN = 64;
    localparam int W = 2 * XLEN + 2;
    localparam logic signed [W-1:0] ONE = W'(1);

    typedef struct {
        logic [XLEN-1:0] pri;
        logic [XLEN-1:0] sec;
        string           tag;
    } exp_t;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic signed [XLEN-1:0] op_a = '0;
    logic signed [XLEN-1:0] op_b = '0;
    logic signed [XLEN-1:0] coef = '0;
    logic [4:0]             shamt = '0;
    logic                   out_valid;
    logic [XLEN-1:0]        res_pri;
    logic [XLEN-1:0]        res_sec;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    logic vld_d = 1'b0;
    exp_t sb[$];
    exp_t last_exp;

    always #10 clk = ~clk;

    tbf_twin_butterfly #(.XLEN(XLEN)) u_tbf_twin_butterfly (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .coef      (coef),
        .shamt     (shamt),
        .out_valid (out_valid),
        .res_pri   (res_pri),
        .res_sec   (res_sec)
    );

    // Arithmetic reference: wide exact value, optional rounding bias, arithmetic shift.
    function automatic logic [XLEN-1:0] ref_val(input logic signed [W-1:0] s,
                                                input logic signed [XLEN-1:0] c,
                                                input int n);
        logic signed [W-1:0] p;
        p = s * W'(c);
        if (n != 0) p = (p + (ONE <<< (n - 1))) >>> n;
        return p[XLEN-1:0];
    endfunction

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic signed [XLEN-1:0] a, input logic signed [XLEN-1:0] b,
                         input logic signed [XLEN-1:0] c, input int n, input string tag);
        exp_t e;
        logic signed [W-1:0] sa, sb_;
        sa  = W'(a);
        sb_ = W'(b);
        e.pri = ref_val(sa + sb_, c, n);
        e.sec = ref_val(sa - sb_, c, n);
        e.tag = tag;
        @(negedge clk);
        op_a = a; op_b = b; coef = c; shamt = 5'(n); in_valid = 1'b1;
        sb.push_back(e);
        last_exp = e;
    endtask

    task automatic idle(input int k);
        @(negedge clk);
        in_valid = 1'b0;
        op_a = $signed(XLEN'($urandom)); op_b = -op_a; coef = 64'sd7; shamt = 5'd3;
        for (int i = 1; i < k; i++) @(negedge clk);
    endtask

    // Reference valid timing: the strobe seen at each edge.
    always @(posedge clk) vld_d <= rst_n ? in_valid : 1'b0;

    // Monitor: compare valid timing every cycle and pop results on valid.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 out_valid timing", XLEN'(out_valid), XLEN'(vld_d));
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R7 unexpected result", XLEN'(1), XLEN'(0));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " primary"},   res_pri, e.pri);
                    check({e.tag, " secondary"}, res_sec, e.sec);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic signed [XLEN-1:0] maxv, minv;
        maxv = {1'b0, {(XLEN-1){1'b1}}};
        minv = {1'b1, {(XLEN-1){1'b0}}};
        // Drive nonzero inputs during reset: the outputs must stay clear (R10).
        in_valid = 1'b1; op_a = 64'sd5; op_b = 64'sd3; coef = 64'sd9; shamt = 5'd1;
        repeat (3) @(negedge clk);
        check("R10 reset out_valid", XLEN'(out_valid), '0);
        check("R10 reset res_pri", res_pri, '0);
        check("R10 reset res_sec", res_sec, '0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Codec-style step at shift 14.
        drive(64'sd100, 64'sd50, 64'sd11585, 14, "R4 codec shift14");
        idle(3);
        check("R9 hold primary", res_pri, last_exp.pri);
        check("R9 hold secondary", res_sec, last_exp.sec);
        check("R8 idle valid low", XLEN'(out_valid), '0);

        // Zero shift: truncation, no rounding, wrap of the product.
        drive(64'sd3, -64'sd5, 64'sh4000_0000_0000_0001, 0, "R3 truncation");
        drive(64'sd7, 64'sd1, 64'sd3, 0, "R3 small truncation");
        // Widened sum at the extremes.
        drive(maxv, maxv, 64'sd1, 1, "R1 max sum");
        drive(minv, maxv, 64'sd1, 1, "R1 min minus max");
        drive(minv, minv, -64'sd1, 0, "R1 R2 min pair neg coef");
        // Rounding ties at shift 1.
        drive(-64'sd3, 64'sd0, 64'sd1, 1, "R5 minus three");
        drive(-64'sd1, 64'sd0, 64'sd1, 1, "R5 minus one");
        drive(64'sd3, 64'sd0, 64'sd1, 1, "R5 plus three");
        // Lane routing: difference is a minus b.
        drive(64'sd10, 64'sd30, 64'sd1, 0, "R6 lane order");
        drive(-64'sd1000, 64'sd250, -64'sd15137, 13, "R2 R6 negative coef");
        drive(64'sd1 <<< 40, 64'sd12345, 64'sd3, 31, "R4 shift31");
        idle(2);

        // Back-to-back strobes with varied shifts and signs.
        for (int i = 0; i < 60; i++) begin
            drive($signed(XLEN'({$urandom, $urandom})), $signed(XLEN'({$urandom, $urandom})),
                  $signed(XLEN'($signed(16'($urandom)))), i % 32, "R7 stream");
        end
        idle(4);
        check("R9 hold after stream", res_pri, last_exp.pri);
        check("R7 scoreboard drained", XLEN'(sb.size()), '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule